// File: doc/BRIEF.md
# DMA Peripheral Request Handshaker

This block sits on the peripheral side of a DMA controller's request/acknowledge link. It raises typed requests toward the controller on a request channel (valid, ready, type) and takes typed acknowledges back on an acknowledge channel (valid, ready, type). A local `burst_req_i` input from the data path asks for burst transfers. The block answers a flush that the controller starts with a single flush-typed request.

The sequencing is a four-state machine:
- `ST_IDLE`: no request is outstanding.
- `ST_BURST_REQ`: a burst request is being offered.
- `ST_WAIT_ACK`: the burst request was accepted and the block waits for its acknowledge.
- `ST_FLUSH_REQ`: a flush answer is being offered.

The named transitions are:
- IDLE→BURST_REQ when `burst_req_i` is high.
- IDLE→FLUSH_REQ on a flush acknowledge.
- BURST_REQ→WAIT_ACK on the request handshake.
- BURST_REQ→FLUSH_REQ on the handshake when a flush is pending or arrives in the same cycle.
- WAIT_ACK→BURST_REQ on a burst acknowledge while `burst_req_i` is high.
- WAIT_ACK→IDLE on a burst acknowledge while `burst_req_i` is low.
- WAIT_ACK→FLUSH_REQ on a flush acknowledge.
- WAIT_ACK→WAIT_ACK on a single acknowledge.
- FLUSH_REQ→IDLE on the request handshake.

Type codes on both channels are 2 bits: 00 single, 01 burst, 10 flush. Code 11 is reserved and ignored.

Top module: `dmahs_handshaker`

## Requirements
- R1: After reset, `ack_ready_o` is 1 and `req_valid_o` is 0. `ack_ready_o` stays 1 at all times.
- R2: In IDLE with no flush acknowledge arriving, a sampled high `burst_req_i` makes `req_valid_o` 1 with `req_type_o`=01 from the next cycle on.
- R3: While `req_valid_o` is 1 and `req_ready_i` is 0, `req_valid_o` stays 1 and `req_type_o` keeps its value for any number of cycles.
- R4: A burst acknowledge (type 01) in WAIT_ACK raises a new burst request on the next cycle if `burst_req_i` is 1. If `burst_req_i` is 0, the block returns to idle with `req_valid_o` 0.
- R5: Single acknowledges (type 00) in WAIT_ACK raise no request, and the block stays in WAIT_ACK.
- R6: A flush acknowledge (type 10) in WAIT_ACK makes `req_valid_o` 1 with type 10 on the next cycle. After one handshake, `req_valid_o` drops to 0.
- R7: A flush acknowledge in IDLE is answered the same way as in R6.
- R8: A flush acknowledge that arrives while a burst request is being offered does not change the offered type. Once the burst handshakes, a type-10 request follows on the next cycle.
- R9: `req_valid_o` falls only in a cycle after `req_valid_o` and `req_ready_i` were both 1.
- R10: Dropping `burst_req_i` while a burst request is offered does not withdraw that request.
- R11: In IDLE, acknowledges of type 00, 01 or 11 are ignored and `req_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_req_i | input | 1 | Burst wanted by the data path |
| req_valid_o | output | 1 | Request channel valid |
| req_ready_i | input | 1 | Request channel ready from the controller |
| req_type_o | output | 2 | Request type (00 single, 01 burst, 10 flush) |
| ack_valid_i | input | 1 | Acknowledge channel valid |
| ack_ready_o | output | 1 | Acknowledge channel ready |
| ack_type_i | input | 2 | Acknowledge type (00 single, 01 burst, 10 flush) |

## Verification
Two events can fall in the same cycle: a flush acknowledge from the controller and the handshake of an offered burst request. The bench provokes this by presenting a type-10 acknowledge with `req_ready_i` high while a burst is being offered. It also presents the flush several cycles before the handshake. In both cases it expects the burst type to persist up to the handshake and then exactly one flush-typed request. Other cases are swept over stall lengths of 0 to 20 cycles and single-acknowledge runs of 1 to 16, with the expected valid and type worked out from the cycle count.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
    localparam int TYPE_W = 2;

    typedef enum logic [TYPE_W-1:0] {
        XFER_SINGLE = 2'b00,
        XFER_BURST  = 2'b01,
        XFER_FLUSH  = 2'b10,
        XFER_RSVD   = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BURST_REQ,
        ST_WAIT_ACK,
        ST_FLUSH_REQ
    } st_e;

    typedef struct packed {
        logic single;
        logic burst;
        logic flush;
    } ack_ev_t;
endpackage

// File: rtl/dmahs_ack_decode.sv
module dmahs_ack_decode
    import dmahs_pkg::*;
(
    input  logic              ack_valid_i,
    input  logic              ack_ready_i,
    input  logic [TYPE_W-1:0] ack_type_i,
    output ack_ev_t           ev_o
);
    logic fire;

    assign fire = ack_valid_i && ack_ready_i;

    always_comb begin
        ev_o = '0;
        if (fire) begin
            unique case (xfer_e'(ack_type_i))
                XFER_SINGLE: ev_o.single = 1'b1;
                XFER_BURST:  ev_o.burst  = 1'b1;
                XFER_FLUSH:  ev_o.flush  = 1'b1;
                XFER_RSVD:   ev_o        = '0;
            endcase
        end
    end

    always_comb begin
        assert ($countones(ev_o) <= 1)
            else $error("a_r11_ack_decode_onehot");
    end
endmodule

// File: rtl/dmahs_req_fsm.sv
module dmahs_req_fsm
    import dmahs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req_i,
    input  logic              req_ready_i,
    input  ack_ev_t           ev_i,
    output logic              req_valid_o,
    output logic [TYPE_W-1:0] req_type_o
);
    st_e  state_q, state_d;
    logic fl_pend_q, fl_pend_d;
    logic hs;

    assign hs = req_valid_o && req_ready_i;

    always_comb begin
        state_d   = state_q;
        fl_pend_d = fl_pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_i.flush)
                    state_d = ST_FLUSH_REQ;
                else if (burst_req_i)
                    state_d = ST_BURST_REQ;
            end
            ST_BURST_REQ: begin
                if (hs) begin
                    state_d   = (fl_pend_q || ev_i.flush) ? ST_FLUSH_REQ : ST_WAIT_ACK;
                    fl_pend_d = 1'b0;
                end else if (ev_i.flush) begin
                    fl_pend_d = 1'b1;
                end
            end
            ST_WAIT_ACK: begin
                if (ev_i.flush)
                    state_d = ST_FLUSH_REQ;
                else if (ev_i.burst)
                    state_d = burst_req_i ? ST_BURST_REQ : ST_IDLE;
            end
            ST_FLUSH_REQ: begin
                if (hs)
                    state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            fl_pend_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            fl_pend_q <= fl_pend_d;
        end
    end

    always_comb begin
        req_valid_o = 1'b0;
        req_type_o  = XFER_SINGLE;
        unique case (state_q)
            ST_IDLE:      ;
            ST_BURST_REQ: begin req_valid_o = 1'b1; req_type_o = XFER_BURST; end
            ST_WAIT_ACK:  ;
            ST_FLUSH_REQ: begin req_valid_o = 1'b1; req_type_o = XFER_FLUSH; end
        endcase
    end

    a_r2_burst_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && burst_req_i && !ev_i.flush)
        |=> (req_valid_o && req_type_o == XFER_BURST));

    a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_type_o)));

    a_r5_single_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ACK && ev_i.single) |=> !req_valid_o);

    a_r6_flush_answer: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_ACK || state_q == ST_IDLE) && ev_i.flush)
        |=> (req_valid_o && req_type_o == XFER_FLUSH));

    a_r9_drop_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_valid_o) |-> $past(req_ready_i));

    a_r8_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_type_o != XFER_RSVD));
endmodule

// File: rtl/dmahs_handshaker.sv
module dmahs_handshaker
    import dmahs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [TYPE_W-1:0] req_type_o,
    input  logic              ack_valid_i,
    output logic              ack_ready_o,
    input  logic [TYPE_W-1:0] ack_type_i
);
    ack_ev_t ev;

    assign ack_ready_o = 1'b1;

    dmahs_ack_decode u_ack_dec (
        .ack_valid_i (ack_valid_i),
        .ack_ready_i (ack_ready_o),
        .ack_type_i  (ack_type_i),
        .ev_o        (ev)
    );

    dmahs_req_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_req_i (burst_req_i),
        .req_ready_i (req_ready_i),
        .ev_i        (ev),
        .req_valid_o (req_valid_o),
        .req_type_o  (req_type_o)
    );
endmodule

// File: tb/dmahs_handshaker_tb_top.sv
module dmahs_handshaker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_req = 1'b0;
    logic       req_ready = 1'b0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_type = 2'b00;
    logic       req_valid;
    logic [1:0] req_type;
    logic       ack_ready;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [2:0] IDLE_V = 3'b000;
    localparam logic [2:0] BURST_V = 3'b101;
    localparam logic [2:0] FLUSH_V = 3'b110;

    always #2.5 clk = ~clk;

    dmahs_handshaker dut_i (
        .clk(clk), .rst_n(rst_n), .burst_req_i(burst_req),
        .req_valid_o(req_valid), .req_ready_i(req_ready), .req_type_o(req_type),
        .ack_valid_i(ack_valid), .ack_ready_o(ack_ready), .ack_type_i(ack_type)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [2:0] exp, input string tag);
        checks++;
        if ({req_valid, req_type} !== exp || ack_ready !== 1'b1) begin
            fails++;
            $display("FAIL %s: got valid/type=%b ack_ready=%b, expected %b ack_ready=1",
                     tag, {req_valid, req_type}, ack_ready, exp);
        end
    endtask

    task automatic ack(input logic [1:0] t);
        ack_valid = 1'b1; ack_type = t;
        step();
        ack_valid = 1'b0;
    endtask

    task automatic to_wait_ack();
        burst_req = 1'b1; step(); burst_req = 1'b0;
        req_ready = 1'b1; step(); req_ready = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk(IDLE_V, "R1 reset");
        rst_n = 1'b1;
        step();
        chk(IDLE_V, "R1 after release");

        // R2/R3/R9/R10: stall sweep, burst_req dropped after first cycle
        for (int n = 0; n <= 20; n++) begin
            burst_req = 1'b1; step();
            chk(BURST_V, "R2 raise");
            burst_req = 1'b0;
            for (int k = 0; k < n; k++) begin
                step();
                chk(BURST_V, "R3 R10 hold");
            end
            req_ready = 1'b1; step(); req_ready = 1'b0;
            chk(IDLE_V, "R9 drop after handshake");
            ack(2'b01);
            chk(IDLE_V, "R4 burst ack, input low");
        end

        // R5/R4: single ack runs then burst ack with input high
        for (int n = 1; n <= 16; n++) begin
            to_wait_ack();
            for (int k = 0; k < n; k++) begin
                ack(2'b00);
                chk(IDLE_V, "R5 single ack quiet");
            end
            burst_req = 1'b1;
            ack(2'b01);
            chk(BURST_V, "R4 re-raise");
            req_ready = 1'b1; step(); req_ready = 1'b0;
            burst_req = 1'b0;
            ack(2'b01);
            chk(IDLE_V, "R4 back to idle");
        end

        // R6: flush in wait-ack, with 0..4 stall cycles on flush request
        for (int n = 0; n <= 4; n++) begin
            to_wait_ack();
            ack(2'b10);
            chk(FLUSH_V, "R6 flush answer");
            for (int k = 0; k < n; k++) begin
                step();
                chk(FLUSH_V, "R6 R3 flush hold");
            end
            req_ready = 1'b1; step(); req_ready = 1'b0;
            chk(IDLE_V, "R6 single flush cycle");
        end

        // R7: flush while idle
        ack(2'b10);
        chk(FLUSH_V, "R7 idle flush");
        req_ready = 1'b1; step(); req_ready = 1'b0;
        chk(IDLE_V, "R7 drop");

        // R11: ignored acks in idle
        for (int t = 0; t < 4; t++) begin
            if (t == 2) continue;
            ack(2'(t));
            chk(IDLE_V, "R11 idle ack ignored");
            step();
            chk(IDLE_V, "R11 still idle");
        end

        // R8: flush same cycle as burst handshake
        burst_req = 1'b1; step(); burst_req = 1'b0;
        req_ready = 1'b1; ack_valid = 1'b1; ack_type = 2'b10;
        step();
        ack_valid = 1'b0; req_ready = 1'b0;
        chk(FLUSH_V, "R8 coincident flush");
        req_ready = 1'b1; step(); req_ready = 1'b0;
        chk(IDLE_V, "R8 flush done");

        // R8: flush earlier than handshake
        burst_req = 1'b1; step(); burst_req = 1'b0;
        ack(2'b10);
        chk(BURST_V, "R8 burst type kept");
        step();
        chk(BURST_V, "R8 burst still held");
        req_ready = 1'b1; step(); req_ready = 1'b0;
        chk(FLUSH_V, "R8 deferred flush");
        req_ready = 1'b1; step(); req_ready = 1'b0;
        chk(IDLE_V, "R8 deferred flush done");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule